// File: doc/BRIEF.md
# Tiled Character Scanline Renderer

This block produces the 4-bit pixel stream for one visible scanline of a tile-mapped character display. A one-clock line-start strobe begins the line. The block then walks across 16 tile positions, each given exactly 24 clocks. For each position it reads an 8-bit tile index from a tile-map memory and turns that index into a font address. It then reads two packed font bytes, each holding two 4-bit pixels, and places four pixels on the output at fixed clock slots.

Tiles fall into two classes. A tile whose index is at or above a programmable threshold counts as graphics, and its last pixel runs on into the setup window of the next tile. A tile below the threshold counts as text, and the output is forced to a programmable blank level during that window, which leaves a gap between characters. The blank level, the threshold, the tile-map row base and the font row base are captured when the strobe is accepted. The surrounding video timing decides when each line starts. Both memories have synchronous read ports with a read latency of one clock.

Top module: `tile_line_renderer`

## Requirements
- R1: Edge 0 is the rising edge that accepts lineStart. Pixel p (0..3) of tile t (0..15) first appears on pixOut at rising edge 24*t + 12 + 4*p after edge 0. It stays there until the next update that R4, R5 or R7 define.
- R2: For a tile with index {hi,lo} (two nibbles), the two font reads go to fontRowBase + (lo << 8) + (hi << 4) and to that address plus 1, modulo 2^16. A line makes exactly 32 font reads.
- R3: Each font byte supplies its bits [3:0] first and its bits [7:4] four clocks later. The first byte of a tile gives pixels 0 and 1, and the second byte gives pixels 2 and 3.
- R4: If the index of tile t-1 is greater than or equal to the threshold (unsigned compare), pixel 3 of tile t-1 stays on pixOut until pixel 0 of tile t appears.
- R5: If the index of tile t-1 is below the threshold, pixOut takes the blank level at edge 24*t + 4. Tile 0 always starts this way, as if its predecessor were below the threshold.
- R6: The index of tile t is read from tile-map address (mapRowBase + t) modulo 256. The read for tile t+1 overlaps the pixel output of tile t. Read data is valid on the clock after the enable. A line makes exactly 16 map reads.
- R7: At edge 388, pixOut returns to the blank level and lineDone is high for exactly one clock. After that, no read enable is asserted until the next accepted strobe.
- R8: The block captures the four configuration inputs at edge 0. Later changes to those inputs, and any lineStart pulse that arrives while a line is in progress, do not affect the line.
- R9: After reset, pixOut and lineDone are 0 and both read enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, synchronous |
| lineStart | input | 1 | One-clock strobe that starts a scanline |
| cfgBlank | input | 4 | Blank level for text gaps and idle time |
| cfgThreshold | input | 8 | Lowest tile index treated as graphics |
| mapRowBase | input | 8 | Tile-map address of the first tile of the row |
| fontRowBase | input | 16 | Font address of the current pixel row |
| mapRdEn | output | 1 | Tile-map read enable |
| mapRdAddr | output | 8 | Tile-map read address |
| mapRdData | input | 8 | Tile-map read data, one clock after the enable |
| fontRdEn | output | 1 | Font read enable |
| fontRdAddr | output | 16 | Font read address |
| fontRdData | input | 8 | Font read data, one clock after the enable |
| pixOut | output | 4 | Pixel output |
| lineDone | output | 1 | One-clock pulse at the end of the line |

## Verification
The bench builds the block with its default parameters: 16 tiles of 24 clocks, an 8-bit tile index, an 8-bit tile-map address and a 16-bit font address. These sizes let a full line be compared on every clock against a model that derives pixels from the tile map and a computed font. They also bring both address wrap-arounds within reach: a map row base of 0xF8 makes the tile-map address wrap, and a font row base of 0xF800 with large indices makes the font address wrap. Thresholds of 0x00, 0x40, 0x80 and 0x90 cover all-extend lines, all-blank lines and a line that alternates indices exactly at and just below the threshold.

// File: rtl/tlr_pkg.sv
package tlr_pkg;

  localparam int TLR_PIX_W   = 4;
  localparam int TLR_FONT_DW = 8;
  localparam int TLR_MIN_TILE_CLKS = 24;

  // Action phases: a strobe decoded in phase k takes effect at the edge
  // that ends that phase, i.e. relative tile clock k+1.
  localparam int TLR_PH_BLANK = 3;
  localparam int TLR_PH_LOAD  = 4;
  localparam int TLR_PH_RD_LO = 10;
  localparam int TLR_PH_PIX0  = 11;
  localparam int TLR_PH_FETCH = 12;
  localparam int TLR_PH_PIX1  = 15;
  localparam int TLR_PH_RD_HI = 18;
  localparam int TLR_PH_PIX2  = 19;
  localparam int TLR_PH_PIX3  = 23;

  typedef struct packed {
    logic start;
    logic mapRd;
    logic capNext;
    logic loadTile;
    logic blankSlot;
    logic edgeTile;
    logic fontRdLo;
    logic fontRdHi;
    logic pixLo;
    logic pixHi;
    logic rstAddr;
    logic lineEnd;
  } tlr_strobe_t;

endpackage

// File: rtl/tlr_ctrl.sv
module tlr_ctrl
  import tlr_pkg::*;
#(
  parameter int NUM_TILES = 16,
  parameter int TILE_CLKS = 24,
  parameter int MAP_AW    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineStart,
  output tlr_strobe_t       strb,
  output logic [MAP_AW-1:0] mapOffs
);

  localparam int TILE_W = $clog2(NUM_TILES + 1);
  localparam int PH_W   = $clog2(TILE_CLKS);

  logic              busy;
  logic [TILE_W-1:0] tile;
  logic [PH_W-1:0]   phase;
  logic              inLine;
  logic              endTile;
  logic              lastTile;
  logic              tileZero;

  function automatic logic atPh(input logic [PH_W-1:0] ph, input int k);
    return ph == PH_W'(k);
  endfunction

  always_comb begin
    inLine   = busy && (tile < TILE_W'(NUM_TILES));
    endTile  = busy && (tile == TILE_W'(NUM_TILES));
    lastTile = (tile == TILE_W'(NUM_TILES - 1));
    tileZero = (tile == '0);

    strb.start     = lineStart && !busy;
    strb.mapRd     = inLine && ((tileZero && atPh(phase, 0)) ||
                                (atPh(phase, TLR_PH_FETCH) && !lastTile));
    strb.capNext   = inLine && ((tileZero && atPh(phase, 1)) ||
                                (atPh(phase, TLR_PH_FETCH + 1) && !lastTile));
    strb.loadTile  = inLine && atPh(phase, TLR_PH_LOAD);
    strb.blankSlot = busy && atPh(phase, TLR_PH_BLANK);
    strb.edgeTile  = tileZero || endTile;
    strb.fontRdLo  = inLine && atPh(phase, TLR_PH_RD_LO);
    strb.fontRdHi  = inLine && atPh(phase, TLR_PH_RD_HI);
    strb.pixLo     = inLine && (atPh(phase, TLR_PH_PIX0) || atPh(phase, TLR_PH_PIX2));
    strb.pixHi     = inLine && (atPh(phase, TLR_PH_PIX1) || atPh(phase, TLR_PH_PIX3));
    strb.rstAddr   = inLine && atPh(phase, TLR_PH_PIX2);
    strb.lineEnd   = endTile && atPh(phase, TLR_PH_BLANK);

    mapOffs = atPh(phase, TLR_PH_FETCH) ? MAP_AW'(tile + 1'b1) : MAP_AW'(tile);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy  <= 1'b0;
      tile  <= '0;
      phase <= '0;
    end else if (strb.start) begin
      busy  <= 1'b1;
      tile  <= '0;
      phase <= '0;
    end else if (busy) begin
      if (strb.lineEnd) begin
        busy  <= 1'b0;
        tile  <= '0;
        phase <= '0;
      end else if (phase == PH_W'(TILE_CLKS - 1)) begin
        phase <= '0;
        tile  <= tile + 1'b1;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (phase < PH_W'(TILE_CLKS))) else $error("phase out of range"); // R1

  AST_HI_AFTER_LO: assert property (@(posedge clk) disable iff (!rstN)
    strb.fontRdHi |-> $past(strb.fontRdLo, 8)) else $error("second font read unpaired"); // R2

  AST_ONE_START: assert property (@(posedge clk) disable iff (!rstN)
    (lineStart && busy) |=> busy) else $error("strobe disturbed running line"); // R8

endmodule

// File: rtl/tlr_datapath.sv
module tlr_datapath
  import tlr_pkg::*;
#(
  parameter int IDX_W   = 8,
  parameter int MAP_AW  = 8,
  parameter int FONT_AW = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  tlr_strobe_t          strb,
  input  logic [MAP_AW-1:0]    mapOffs,
  input  logic [TLR_PIX_W-1:0] cfgBlank,
  input  logic [IDX_W-1:0]     cfgThreshold,
  input  logic [MAP_AW-1:0]    mapRowBase,
  input  logic [FONT_AW-1:0]   fontRowBase,
  output logic                 mapRdEn,
  output logic [MAP_AW-1:0]    mapRdAddr,
  input  logic [IDX_W-1:0]     mapRdData,
  output logic                 fontRdEn,
  output logic [FONT_AW-1:0]   fontRdAddr,
  input  logic [TLR_FONT_DW-1:0] fontRdData,
  output logic [TLR_PIX_W-1:0] pixOut,
  output logic                 lineDone
);

  localparam int NIB    = IDX_W / 2;
  localparam int OFFS_W = 3 * NIB;
  localparam int PW     = TLR_PIX_W;

  logic [PW-1:0]          blankReg;
  logic [IDX_W-1:0]       thrReg;
  logic [MAP_AW-1:0]      mapBaseReg;
  logic [FONT_AW-1:0]     fontBaseReg;
  logic [FONT_AW-1:0]     fontAddr;
  logic [IDX_W-1:0]       nextIdx;
  logic [IDX_W-1:0]       curIdx;
  logic [TLR_FONT_DW-1:0] holdByte;
  logic [OFFS_W-1:0]      offsRaw;
  logic [FONT_AW-1:0]     tileOffs;
  logic                   doBlank;

  always_comb begin
    // low nibble lands in the upper address byte, high nibble stays put
    offsRaw  = {nextIdx[NIB-1:0], nextIdx[IDX_W-1:NIB], {NIB{1'b0}}};
    tileOffs = FONT_AW'(offsRaw);
    doBlank  = strb.blankSlot && (strb.edgeTile || (curIdx < thrReg));

    mapRdEn    = strb.mapRd;
    mapRdAddr  = mapBaseReg + mapOffs;
    fontRdEn   = strb.fontRdLo || strb.fontRdHi;
    fontRdAddr = fontAddr + FONT_AW'(strb.fontRdHi);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blankReg    <= '0;
      thrReg      <= '0;
      mapBaseReg  <= '0;
      fontBaseReg <= '0;
      fontAddr    <= '0;
      nextIdx     <= '0;
      curIdx      <= '0;
    end else begin
      if (strb.start) begin
        blankReg    <= cfgBlank;
        thrReg      <= cfgThreshold;
        mapBaseReg  <= mapRowBase;
        fontBaseReg <= fontRowBase;
        fontAddr    <= fontRowBase;
      end
      if (strb.capNext) nextIdx <= mapRdData;
      if (strb.loadTile) begin
        curIdx   <= nextIdx;
        fontAddr <= fontAddr + tileOffs;
      end
      if (strb.rstAddr) fontAddr <= fontBaseReg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixOut   <= '0;
      holdByte <= '0;
      lineDone <= 1'b0;
    end else begin
      lineDone <= strb.lineEnd;
      if (doBlank) begin
        pixOut <= blankReg;
      end else if (strb.pixLo) begin
        pixOut   <= fontRdData[PW-1:0];
        holdByte <= {fontRdData[PW-1:0], fontRdData[TLR_FONT_DW-1:PW]};
      end else if (strb.pixHi) begin
        pixOut <= holdByte[PW-1:0];
      end
    end
  end

  AST_PIX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.blankSlot || strb.pixLo || strb.pixHi) |=> $stable(pixOut))
    else $error("pixel changed off slot"); // R1

  AST_EXTEND_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.blankSlot && !strb.edgeTile && (curIdx >= thrReg)) |=> $stable(pixOut))
    else $error("graphics tile not extended"); // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    lineDone |=> !lineDone) else $error("lineDone longer than one clock"); // R7

endmodule

// File: rtl/tile_line_renderer.sv
module tile_line_renderer
  import tlr_pkg::*;
#(
  parameter int NUM_TILES = 16,
  parameter int TILE_CLKS = 24,
  parameter int IDX_W     = 8,
  parameter int MAP_AW    = 8,
  parameter int FONT_AW   = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   lineStart,
  input  logic [TLR_PIX_W-1:0]   cfgBlank,
  input  logic [IDX_W-1:0]       cfgThreshold,
  input  logic [MAP_AW-1:0]      mapRowBase,
  input  logic [FONT_AW-1:0]     fontRowBase,
  output logic                   mapRdEn,
  output logic [MAP_AW-1:0]      mapRdAddr,
  input  logic [IDX_W-1:0]       mapRdData,
  output logic                   fontRdEn,
  output logic [FONT_AW-1:0]     fontRdAddr,
  input  logic [TLR_FONT_DW-1:0] fontRdData,
  output logic [TLR_PIX_W-1:0]   pixOut,
  output logic                   lineDone
);

  tlr_strobe_t       strb;
  logic [MAP_AW-1:0] mapOffs;

  tlr_ctrl #(
    .NUM_TILES (NUM_TILES),
    .TILE_CLKS (TILE_CLKS),
    .MAP_AW    (MAP_AW)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .lineStart (lineStart),
    .strb      (strb),
    .mapOffs   (mapOffs)
  );

  tlr_datapath #(
    .IDX_W   (IDX_W),
    .MAP_AW  (MAP_AW),
    .FONT_AW (FONT_AW)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .mapOffs      (mapOffs),
    .cfgBlank     (cfgBlank),
    .cfgThreshold (cfgThreshold),
    .mapRowBase   (mapRowBase),
    .fontRowBase  (fontRowBase),
    .mapRdEn      (mapRdEn),
    .mapRdAddr    (mapRdAddr),
    .mapRdData    (mapRdData),
    .fontRdEn     (fontRdEn),
    .fontRdAddr   (fontRdAddr),
    .fontRdData   (fontRdData),
    .pixOut       (pixOut),
    .lineDone     (lineDone)
  );

  AST_MAP_SPACED: assert property (@(posedge clk) disable iff (!rstN)
    mapRdEn |=> !mapRdEn) else $error("back-to-back map reads"); // R6

  AST_READ_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(mapRdEn && fontRdEn)) else $error("map and font read together"); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    lineDone |-> !(mapRdEn || fontRdEn)) else $error("read after line end"); // R7

endmodule

// File: tb/tile_line_renderer_tb_top.sv
module tile_line_renderer_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lineStart = 1'b0;
  logic [3:0]  cfgBlank = '0;
  logic [7:0]  cfgThreshold = '0;
  logic [7:0]  mapRowBase = '0;
  logic [15:0] fontRowBase = '0;
  logic        mapRdEn;
  logic [7:0]  mapRdAddr;
  logic [7:0]  mapRdData = '0;
  logic        fontRdEn;
  logic [15:0] fontRdAddr;
  logic [7:0]  fontRdData = '0;
  logic [3:0]  pixOut;
  logic        lineDone;

  int checks = 0;
  int errors = 0;

  logic [7:0] mapMem [256];
  int mBaseR, fBaseR, thrR, blankR;
  logic [3:0] idleVal = 4'h0;

  always #4 clk = ~clk;

  tile_line_renderer dut_i (
    .clk (clk), .rstN (rstN), .lineStart (lineStart),
    .cfgBlank (cfgBlank), .cfgThreshold (cfgThreshold),
    .mapRowBase (mapRowBase), .fontRowBase (fontRowBase),
    .mapRdEn (mapRdEn), .mapRdAddr (mapRdAddr), .mapRdData (mapRdData),
    .fontRdEn (fontRdEn), .fontRdAddr (fontRdAddr), .fontRdData (fontRdData),
    .pixOut (pixOut), .lineDone (lineDone)
  );

  function automatic logic [7:0] fontByte(input logic [15:0] a);
    return 8'(a[7:0] * 8'd37) ^ a[15:8] ^ 8'hA5;
  endfunction

  always @(posedge clk) begin
    if (mapRdEn)  mapRdData  <= mapMem[mapRdAddr];
    if (fontRdEn) fontRdData <= fontByte(fontRdAddr);
  end

  function automatic int tileIdx(input int t);
    return int'(mapMem[(mBaseR + t) & 255]);
  endfunction

  // R2 address formula, R3 nibble order
  function automatic logic [3:0] expPix(input int t, input int p);
    int idx = tileIdx(t);
    int a = (fBaseR + ((idx & 15) << 8) + (idx & 240) + p / 2) & 65535;
    logic [7:0] b = fontByte(16'(a));
    return (p % 2 == 1) ? b[7:4] : b[3:0];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp,
                     input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(pixOut == 4'h0, "R9", pixOut, 0, "pixOut after reset");
    chk(lineDone == 1'b0, "R9", lineDone, 0, "lineDone after reset");
    chk(!mapRdEn && !fontRdEn, "R9", {mapRdEn, fontRdEn}, 0, "read enables after reset");
  endtask

  // Runs one line and compares every clock against the model.
  task automatic runLine(input int thr, input int blank, input int mBase, input int fBase,
                         input bit disturb, input string tag);
    int mapReads = 0;
    int fontReads = 0;
    logic [3:0] e = idleVal;
    thrR = thr; blankR = blank; mBaseR = mBase; fBaseR = fBase;
    @(negedge clk);
    cfgThreshold = 8'(thr); cfgBlank = 4'(blank);
    mapRowBase = 8'(mBase); fontRowBase = 16'(fBase);
    lineStart = 1'b1;
    @(negedge clk);            // edge 0 has passed
    lineStart = 1'b0;
    if (disturb) begin         // R8: inputs change right after capture
      cfgThreshold = 8'(thr ^ 8'h5A); cfgBlank = 4'(~blank);
      mapRowBase = 8'(mBase + 3); fontRowBase = 16'(fBase + 16'h0230);
    end
    if (mapRdEn) mapReads++;
    if (fontRdEn) fontReads++;
    for (int n = 1; n <= 392; n++) begin
      int t = n / 24;
      int ph = n % 24;
      string req;
      @(negedge clk);
      if (disturb) lineStart = (n == 50 || n == 200);
      if (mapRdEn) mapReads++;
      if (fontRdEn) fontReads++;
      req = "R1 R2 R3";
      if (ph == 4 && (t == 0 || t == 16 || tileIdx(t - 1) < thr)) e = 4'(blank);
      if (t < 16 && (ph == 12 || ph == 16 || ph == 20)) e = expPix(t, (ph - 12) / 4);
      if (ph == 0 && t >= 1 && t <= 16) e = expPix(t - 1, 3);
      if (t >= 1 && t <= 15 && ph >= 1 && ph <= 11)
        req = (tileIdx(t - 1) >= thr) ? "R4" : "R5";
      if (n >= 385) req = "R7";
      if (disturb) req = {"R8 ", req};
      chk(pixOut == e, req, pixOut, e, $sformatf("%s pixOut at edge %0d", tag, n));
      chk(lineDone == (n == 388), "R7", lineDone, (n == 388),
          $sformatf("%s lineDone at edge %0d", tag, n));
      if (n > 388)
        chk(!mapRdEn && !fontRdEn, "R7", {mapRdEn, fontRdEn}, 0,
            $sformatf("%s idle reads at edge %0d", tag, n));
    end
    lineStart = 1'b0;
    chk(mapReads == 16, "R6", mapReads, 16, {tag, " map read count"});
    chk(fontReads == 32, "R2", fontReads, 32, {tag, " font read count"});
    idleVal = 4'(blank);
  endtask

  task automatic testText();   // R5: every index below threshold
    for (int i = 0; i < 256; i++) mapMem[i] = 8'((i * 7 + 3) & 8'h7F);
    runLine(8'h80, 4'hC, 8'h00, 16'h0000, 1'b0, "text");
  endtask

  task automatic testGraphics();  // R4: every index at or above threshold
    for (int i = 0; i < 256; i++) mapMem[i] = 8'(8'h40 + ((i * 13) % 192));
    runLine(8'h40, 4'h1, 8'h20, 16'h1000, 1'b0, "graphics");
  endtask

  task automatic testBoundary();  // R4 R5 R6 wrap, R2 wrap
    for (int i = 0; i < 256; i++)
      mapMem[i] = (i % 3 == 0) ? 8'h90 : (i % 3 == 1) ? 8'h8F : 8'(8'hF0 + (i & 15));
    runLine(8'h90, 4'h6, 8'hF8, 16'hF800, 1'b0, "boundary");
  endtask

  task automatic testDisturb();   // R8 with threshold 0: all extend
    for (int i = 0; i < 256; i++) mapMem[i] = 8'((i * 29 + 5) & 8'hFF);
    runLine(8'h00, 4'hF, 8'h41, 16'h2345, 1'b1, "disturb");
  endtask

  initial begin
    #(200000 * 8);
    checks++;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mapMem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testText();
    testGraphics();
    testBoundary();
    testDisturb();
    testText();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule